// File: doc/BRIEF.md
# Shared-Duration Fault Timeout Timers

This block runs three independent timeout channels that all take their length from one programmable duration value. The three channels serve a fault-handling node: a memory bus protocol timeout, a quiescent waiting period, and a permanent-error window. Software or control logic writes an 8-bit duration. The timeout length in clocks is then the duration times 65536, plus 128. A duration of zero gives the shortest length, 128 clocks.

Each channel has its own start and cancel inputs and its own expiry output. A start pulse arms the channel with the current length. If the channel reaches that length without being cancelled or restarted, it emits a single-cycle expiry pulse. The length is captured when the channel starts, so a later change of the duration affects only timers started after the change. What happens on expiry, such as error reporting or bus switching, belongs to the surrounding logic.

The length formula is parameterised as duration shifted left by `SCALE_SHIFT`, plus `BASE_CYC`. The defaults are 16 and 128. `BASE_CYC` must be at least 2.

Top module: `tot_timers`

## Requirements
- R1: After reset the duration value reads 0, every channel is idle, and no expiry output is high.
- R2: When `dur_wr_en` is high at a clock edge, `dur_value` shows `dur_wr_data` from the next cycle on. Without a write, `dur_value` holds its value.
- R3: A start sampled at edge k makes the expiry output high in the cycle that follows edge k+L, where L = (duration << SCALE_SHIFT) + BASE_CYC. No expiry occurs before that cycle.
- R4: An expiry is exactly one cycle wide, and each uninterrupted start produces exactly one expiry.
- R5: The channels are independent and all use the same shared length. Activity on one channel never produces an expiry on another.
- R6: A cancel on a running channel stops it with no expiry. A cancel on an idle channel has no effect.
- R7: A start on a running channel restarts it with the full length counted from the new start.
- R8: When start and cancel are high together, start wins and the channel restarts.
- R9: A running channel keeps the length it captured at its start, even if the duration is written afterwards. A start in the same cycle as a write uses the value held before the write.
- R10: With default parameters (8-bit duration, shift 16, base 128), a zero duration gives a 128-clock timeout. The counter is wide enough for the largest length, 255 × 65536 + 128.
- R11: A start that arrives in the cycle where the channel would have expired suppresses that expiry and begins a new full-length count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dur_wr_en | input | 1 | Write strobe for the duration value |
| dur_wr_data | input | DUR_W | New duration value |
| dur_value | output | DUR_W | Current duration value |
| start | input | NUM_CH | Per-channel start/restart pulse |
| cancel | input | NUM_CH | Per-channel cancel pulse |
| expire | output | NUM_CH | Per-channel one-cycle expiry pulse |

## Verification
The main bench instance is built with a 4-bit duration, a shift of 2 and a base of 5. Every timeout length is therefore between 5 and 65 clocks. This lets the bench sweep all sixteen duration values and measure each expiry cycle exactly. It also lets it exercise restarts, cancels, captured lengths and start-on-expiry collisions within a short run. A second instance uses the default parameters and shows the 128-clock minimum timeout at full counter width.

// File: rtl/tot_pkg.sv
package tot_pkg;

  typedef enum logic {
    CH_IDLE = 1'b0,
    CH_RUN  = 1'b1
  } ch_state_e;

  // Timeout length in clocks for a given duration value.
  function automatic int unsigned tot_span(input int unsigned dur,
                                           input int unsigned shift,
                                           input int unsigned base);
    return (dur << shift) + base;
  endfunction

endpackage

// File: rtl/tot_dur_reg.sv
module tot_dur_reg #(
  parameter int unsigned DUR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DUR_W-1:0] wr_data,
  output logic [DUR_W-1:0] dur_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) dur_q <= '0;
    else if (wr_en) dur_q <= wr_data;
  end

  AST_DUR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> dur_q == $past(wr_data)); // R2
  AST_DUR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(dur_q)); // R2

endmodule

// File: rtl/tot_span_calc.sv
module tot_span_calc #(
  parameter int unsigned DUR_W       = 8,
  parameter int unsigned SCALE_SHIFT = 16,
  parameter int unsigned BASE_CYC    = 128,
  parameter int unsigned CNT_W       = 24
) (
  input  logic [DUR_W-1:0] dur,
  output logic [CNT_W-1:0] span
);

  // One shared length computation feeds every channel.
  always_comb begin
    span = CNT_W'(tot_pkg::tot_span(int'(dur), SCALE_SHIFT, BASE_CYC));
  end

endmodule

// File: rtl/tot_channel.sv
module tot_channel #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cancel,
  input  logic [CNT_W-1:0] span,
  output logic             expire
);
  import tot_pkg::*;

  ch_state_e        st_q;
  logic [CNT_W-1:0] left_q;
  logic             exp_q;

  // Named internal events for the checks below.
  wire last_w = (st_q == CH_RUN) && (left_q == CNT_W'(1));
  wire fire_w = last_w && !start && !cancel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= CH_IDLE;
      left_q <= '0;
      exp_q  <= 1'b0;
    end else begin
      exp_q <= fire_w;
      if (start) begin
        st_q   <= CH_RUN;
        left_q <= span;
      end else if (cancel || last_w) begin
        st_q   <= CH_IDLE;
        left_q <= '0;
      end else if (st_q == CH_RUN) begin
        left_q <= left_q - CNT_W'(1);
      end
    end
  end

  assign expire = exp_q;

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (st_q == CH_RUN) && (left_q == $past(span))); // R7
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CH_RUN && !start && !cancel && left_q > CNT_W'(1))
      |=> left_q == $past(left_q) - CNT_W'(1)); // R3
  AST_CANCEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel && !start) |=> !expire); // R6
  AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> st_q == CH_IDLE); // R4
  AST_EXPIRE_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> $past(st_q == CH_RUN)); // R3
  AST_START_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !expire); // R11

endmodule

// File: rtl/tot_timers.sv
module tot_timers #(
  parameter int unsigned DUR_W       = 8,
  parameter int unsigned SCALE_SHIFT = 16,
  parameter int unsigned BASE_CYC    = 128,
  parameter int unsigned NUM_CH      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dur_wr_en,
  input  logic [DUR_W-1:0]  dur_wr_data,
  output logic [DUR_W-1:0]  dur_value,
  input  logic [NUM_CH-1:0] start,
  input  logic [NUM_CH-1:0] cancel,
  output logic [NUM_CH-1:0] expire
);

  localparam int unsigned DUR_MAX  = (1 << DUR_W) - 1;
  localparam int unsigned MAX_SPAN = tot_pkg::tot_span(DUR_MAX, SCALE_SHIFT, BASE_CYC);
  localparam int unsigned CNT_W    = $clog2(MAX_SPAN + 1);

  logic [CNT_W-1:0] span_w;

  tot_dur_reg #(.DUR_W(DUR_W)) u_dur (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (dur_wr_en),
    .wr_data (dur_wr_data),
    .dur_q   (dur_value)
  );

  tot_span_calc #(
    .DUR_W(DUR_W), .SCALE_SHIFT(SCALE_SHIFT),
    .BASE_CYC(BASE_CYC), .CNT_W(CNT_W)
  ) u_span (
    .dur  (dur_value),
    .span (span_w)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tot_channel #(.CNT_W(CNT_W)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start[g]),
      .cancel (cancel[g]),
      .span   (span_w),
      .expire (expire[g])
    );
  end

  AST_SPAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (span_w >= CNT_W'(BASE_CYC)) && (span_w <= CNT_W'(MAX_SPAN))); // R10
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    !rst_n |=> expire == '0); // R1

endmodule

// File: tb/tot_timers_bench.sv
module tot_timers_bench;

  localparam int DW = 4, SH = 2, BS = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dur_wr_en = 1'b0;
  logic [DW-1:0] dur_wr_data = '0;
  logic [DW-1:0] dur_value;
  logic [2:0] start = '0, cancel = '0, expire;

  logic [2:0] d_start = '0;
  logic [7:0] d_dur;
  logic [2:0] d_expire;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tot_timers #(.DUR_W(DW), .SCALE_SHIFT(SH), .BASE_CYC(BS), .NUM_CH(3)) u_tot_timers (
    .clk(clk), .rst_n(rst_n), .dur_wr_en(dur_wr_en), .dur_wr_data(dur_wr_data),
    .dur_value(dur_value), .start(start), .cancel(cancel), .expire(expire)
  );

  tot_timers u_tot_timers_dflt (
    .clk(clk), .rst_n(rst_n), .dur_wr_en(1'b0), .dur_wr_data(8'd0),
    .dur_value(d_dur), .start(d_start), .cancel(3'b000), .expire(d_expire)
  );

  function automatic int span_of(input int d);
    return d * (1 << SH) + BS;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic write_dur(input int v);
    dur_wr_en = 1'b1; dur_wr_data = DW'(v);
    step();
    dur_wr_en = 1'b0;
    check(dur_value == DW'(v), "R2", "duration readback", int'(dur_value), v);
  endtask

  task automatic pulse(input logic [2:0] s, input logic [2:0] c);
    start = s; cancel = c;
    step();
    start = '0; cancel = '0;
  endtask

  // Sample n = 1..max_n cycles after the last driven edge.
  task automatic watch(input int ch, input int exp_n, input int max_n, input string req);
    int first = 0, hits = 0, other = 0;
    for (int n = 1; n <= max_n; n++) begin
      step();
      if (expire[ch]) begin
        hits++;
        if (first == 0) first = n;
      end
      for (int c = 0; c < 3; c++) if (c != ch && expire[c]) other++;
    end
    check(first == exp_n, req, "first expiry cycle", first, exp_n);
    check(hits == (exp_n == 0 ? 0 : 1), "R4", "expiry pulse count", hits, exp_n == 0 ? 0 : 1);
    check(other == 0, "R5", "pulses on other channels", other, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    // R1: reset state
    check(dur_value == '0, "R1", "duration after reset", int'(dur_value), 0);
    check(expire == '0, "R1", "expiry after reset", int'(expire), 0);
    rst_n = 1'b1;
    step();
    check(expire == '0, "R1", "expiry after release", int'(expire), 0);

    // R3 R5: sweep every duration, rotating channels
    for (int d = 0; d < 16; d++) begin
      write_dur(d);
      pulse(3'b001 << (d % 3), '0);
      watch(d % 3, span_of(d), span_of(d) + 3, "R3");
    end

    // R5: all channels together share one length
    write_dur(3);
    begin
      int f0 = 0, f1 = 0, f2 = 0;
      pulse(3'b111, '0);
      for (int n = 1; n <= span_of(3) + 2; n++) begin
        step();
        if (expire[0] && f0 == 0) f0 = n;
        if (expire[1] && f1 == 0) f1 = n;
        if (expire[2] && f2 == 0) f2 = n;
      end
      check(f0 == span_of(3), "R5", "ch0 shared length", f0, span_of(3));
      check(f1 == span_of(3), "R5", "ch1 shared length", f1, span_of(3));
      check(f2 == span_of(3), "R5", "ch2 shared length", f2, span_of(3));
    end

    // R6: cancel a running channel, and cancel an idle one
    write_dur(2);
    pulse(3'b001, '0);
    repeat (5) step();
    pulse('0, 3'b001);
    watch(0, 0, 30, "R6");
    pulse('0, 3'b010);
    pulse(3'b010, '0);
    watch(1, span_of(2), span_of(2) + 2, "R6");

    // R7: restart mid-count
    pulse(3'b100, '0);
    repeat (6) step();
    pulse(3'b100, '0);
    watch(2, span_of(2), span_of(2) + 4, "R7");

    // R8: start and cancel together
    pulse(3'b001, 3'b001);
    watch(0, span_of(2), span_of(2) + 2, "R8");

    // R9: write after start keeps the captured length
    write_dur(1);
    pulse(3'b001, '0);
    repeat (2) step();
    write_dur(10);
    watch(0, span_of(1) - 3, span_of(1), "R9");
    // R9: start in the same cycle as a write uses the old value
    dur_wr_en = 1'b1; dur_wr_data = DW'(0);
    pulse(3'b010, '0);
    dur_wr_en = 1'b0;
    watch(1, span_of(10), span_of(10) + 2, "R9");
    pulse(3'b010, '0);
    watch(1, span_of(0), span_of(0) + 2, "R9");

    // R11: start in the would-be expiry cycle
    write_dur(1);
    pulse(3'b100, '0);
    repeat (span_of(1) - 1) step();
    pulse(3'b100, '0);
    check(expire[2] == 1'b0, "R11", "suppressed expiry", int'(expire[2]), 0);
    watch(2, span_of(1), span_of(1) + 2, "R11");

    // R10: default configuration, 128-clock minimum
    check(d_dur == 8'd0, "R10", "default duration", int'(d_dur), 0);
    d_start = 3'b001;
    step();
    d_start = '0;
    begin
      int f = 0;
      for (int n = 1; n <= 131; n++) begin
        step();
        if (d_expire[0] && f == 0) f = n;
      end
      check(f == 128, "R10", "default timeout length", f, 128);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule